// File: doc/BRIEF.md
# Local Interrupt Controller Enable Gate

This block decides whether six processor-local interrupt sources may reach the core. It keeps two enable levels: a global enable held in a base-address register, and a software enable flag held in a spurious-vector register. Beneath them, each source has its own mask bit. All three registers are written through a single-cycle register write port (enable, address, data). Each interrupt output combines these three enable levels with that source's request line. The outputs are combinational from registered state.

Clearing the global enable makes the block behave as if no local controller were fitted. The feature-present output drops, and the software enable and all masks return to their power-up values. A parameter selects the bus mode. In front-side-bus mode, software may set the global enable again at any time. In three-wire-bus mode the clear is sticky until hardware reset, and a lock output reports that state. While locked, only the performance-counter and thermal sources may still be unmasked and delivered.

Top module: `lic_enable_gate`

## Requirements
- R1: After reset, feature_present is 1, ctl_enabled is 0, gen_locked is 0, all six mask bits are 1 and every irq bit is 0 whatever src_req holds.
- R2: A write to address 0x01B with data bit 11 at 0 clears the global enable: feature_present reads 0 from the cycle after the write.
- R3: Clearing the global enable returns the software enable to 0 and all mask bits to 1, so the earlier configuration is lost once the global enable is set again.
- R4: With BUS_MODE front-side-bus, a write to 0x01B with bit 11 at 1 sets feature_present again on the next cycle, and gen_locked stays 0.
- R5: With BUS_MODE three-wire-bus, clearing the global enable sets gen_locked. Later writes of bit 11 at 1 are ignored, so feature_present stays 0 and gen_locked stays 1 until reset.
- R6: While gen_locked is 1, the mask bits of the performance-counter source (bit 3) and the thermal source (bit 4) accept writes to 0x300. For those two sources, irq equals src_req AND NOT mask, and every other irq bit is 0.
- R7: While the global enable is 1, a write to address 0x0F0 loads the software enable from data bit 8. ctl_enabled equals global enable AND software enable.
- R8: While the global enable is 0, writes to 0x0F0 are ignored and ctl_enabled stays 0.
- R9: Writing the software enable to 0 forces all mask bits to 1. Mask writes made while the software enable is 0 leave them all at 1.
- R10: Outside the locked state, irq[i] = global enable AND software enable AND NOT mask[i] AND src_req[i]. The source order is bit 0 LINT0, bit 1 LINT1, bit 2 timer, bit 3 performance counters, bit 4 thermal, bit 5 error.
- R11: With both enables at 1, a write to 0x300 loads mask bit i from data bit i. Writes to any other address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write address |
| wr_data | input | 32 | Register write data |
| src_req | input | 6 | Request lines of the six local sources |
| irq | output | 6 | Gated interrupt per source |
| feature_present | output | 1 | Global enable state, reads as controller present |
| ctl_enabled | output | 1 | Global and software enable both set |
| gen_locked | output | 1 | Global enable cleared and locked until reset |

## Verification
A wrong enable or lock bit shows at once on feature_present, ctl_enabled or gen_locked, one cycle after the write that set it. A wrong mask bit only shows on irq, and only when the matching request is raised and both enables are set. For that reason the bench sweeps every mask value against every request pattern. A lost wipe stays hidden until the global enable is set again. It then shows as an interrupt that should have been masked, so the bench re-enables and re-checks the outputs after every clear.

// File: rtl/lic_pkg.sv
package lic_pkg;

   typedef enum logic {
      BUS_FSB   = 1'b0,
      BUS_3WIRE = 1'b1
   } lic_bus_e;

   localparam int LIC_NSRC = 6;

   // Source positions in the mask and irq vectors
   localparam int SRC_LINT0 = 0;
   localparam int SRC_LINT1 = 1;
   localparam int SRC_TIMER = 2;
   localparam int SRC_PERF  = 3;
   localparam int SRC_THERM = 4;
   localparam int SRC_ERROR = 5;

   // Sources that stay usable while the global enable is locked off
   localparam logic [LIC_NSRC-1:0] LIC_LOCK_KEEP =
      LIC_NSRC'((1 << SRC_PERF) | (1 << SRC_THERM));

endpackage

// File: rtl/lic_enable_regs.sv
module lic_enable_regs #(
   parameter int                 ADDR_W    = 12,
   parameter logic [ADDR_W-1:0]  BASE_ADDR = 12'h01B,
   parameter logic [ADDR_W-1:0]  SVR_ADDR  = 12'h0F0,
   parameter lic_pkg::lic_bus_e  BUS_MODE  = lic_pkg::BUS_FSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_gen_bit,
   input  logic              wr_swen_bit,
   output logic              gen_en,
   output logic              sw_en,
   output logic              locked,
   output logic              force_ones
);

   logic base_hit;
   logic svr_hit;
   logic gen_clr;
   logic gen_set;

   assign base_hit = wr_en && (wr_addr == BASE_ADDR);
   assign svr_hit  = wr_en && (wr_addr == SVR_ADDR) && gen_en;
   assign gen_clr  = base_hit && !wr_gen_bit;
   assign gen_set  = base_hit && wr_gen_bit;

   generate
      if (BUS_MODE == lic_pkg::BUS_3WIRE) begin : g_sticky
         logic lock_q;
         always_ff @(posedge clk) begin
            if (!rst_n)       lock_q <= 1'b0;
            else if (gen_clr) lock_q <= 1'b1;
         end
         assign locked = lock_q;
      end else begin : g_free
         assign locked = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                  gen_en <= 1'b1;
      else if (gen_clr)            gen_en <= 1'b0;
      else if (gen_set && !locked) gen_en <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       sw_en <= 1'b0;
      else if (gen_clr) sw_en <= 1'b0;
      else if (svr_hit) sw_en <= wr_swen_bit;
   end

   assign force_ones = gen_clr || (svr_hit && !wr_swen_bit);

endmodule

// File: rtl/lic_mask_bank.sv
module lic_mask_bank #(
   parameter int                 ADDR_W    = 12,
   parameter int                 NSRC      = 6,
   parameter logic [ADDR_W-1:0]  MASK_ADDR = 12'h300,
   parameter logic [NSRC-1:0]    LOCK_KEEP = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [NSRC-1:0]   wr_bits,
   input  logic              force_ones,
   input  logic              gen_en,
   input  logic              sw_en,
   input  logic              locked,
   output logic [NSRC-1:0]   mask
);

   logic hit;
   logic open_wr;

   assign hit     = wr_en && (wr_addr == MASK_ADDR);
   assign open_wr = hit && gen_en && sw_en;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_bit
         if (LOCK_KEEP[i]) begin : g_keep
            always_ff @(posedge clk) begin
               if (!rst_n)                mask[i] <= 1'b1;
               else if (force_ones)       mask[i] <= 1'b1;
               else if (hit && locked)    mask[i] <= wr_bits[i];
               else if (open_wr)          mask[i] <= wr_bits[i];
            end
         end else begin : g_plain
            always_ff @(posedge clk) begin
               if (!rst_n)                mask[i] <= 1'b1;
               else if (force_ones)       mask[i] <= 1'b1;
               else if (open_wr)          mask[i] <= wr_bits[i];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/lic_delivery_gate.sv
module lic_delivery_gate #(
   parameter int              NSRC      = 6,
   parameter logic [NSRC-1:0] LOCK_KEEP = '0
) (
   input  logic            gen_en,
   input  logic            sw_en,
   input  logic            locked,
   input  logic [NSRC-1:0] mask,
   input  logic [NSRC-1:0] src_req,
   output logic [NSRC-1:0] irq
);

   logic full_on;
   assign full_on = gen_en && sw_en;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         if (LOCK_KEEP[i]) begin : g_keep
            assign irq[i] = src_req[i] && !mask[i] && (full_on || locked);
         end else begin : g_plain
            assign irq[i] = src_req[i] && !mask[i] && full_on;
         end
      end
   endgenerate

endmodule

// File: rtl/lic_enable_gate.sv
module lic_enable_gate #(
   parameter int                ADDR_W    = 12,
   parameter int                DATA_W    = 32,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h01B,
   parameter logic [ADDR_W-1:0] SVR_ADDR  = 12'h0F0,
   parameter logic [ADDR_W-1:0] MASK_ADDR = 12'h300,
   parameter int                GEN_BIT   = 11,
   parameter int                SWEN_BIT  = 8,
   parameter lic_pkg::lic_bus_e BUS_MODE  = lic_pkg::BUS_FSB
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [DATA_W-1:0]           wr_data,
   input  logic [lic_pkg::LIC_NSRC-1:0] src_req,
   output logic [lic_pkg::LIC_NSRC-1:0] irq,
   output logic                        feature_present,
   output logic                        ctl_enabled,
   output logic                        gen_locked
);

   localparam int              NSRC      = lic_pkg::LIC_NSRC;
   localparam logic [NSRC-1:0] LOCK_KEEP = lic_pkg::LIC_LOCK_KEEP;

   generate
      if (GEN_BIT >= DATA_W || SWEN_BIT >= DATA_W || NSRC > DATA_W) begin : g_bad_bits
         $error("lic_enable_gate: a field lies outside wr_data");
      end
      if (BASE_ADDR == SVR_ADDR || BASE_ADDR == MASK_ADDR || SVR_ADDR == MASK_ADDR) begin : g_bad_addr
         $error("lic_enable_gate: register addresses overlap");
      end
   endgenerate

   logic gen_en;
   logic sw_en;
   logic locked;
   logic force_ones;
   logic [NSRC-1:0] mask;
   logic unused_wr_data;

   assign unused_wr_data = ^wr_data;

   lic_enable_regs #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR),
      .SVR_ADDR  (SVR_ADDR),
      .BUS_MODE  (BUS_MODE)
   ) regs_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_gen_bit  (wr_data[GEN_BIT]),
      .wr_swen_bit (wr_data[SWEN_BIT]),
      .gen_en      (gen_en),
      .sw_en       (sw_en),
      .locked      (locked),
      .force_ones  (force_ones)
   );

   lic_mask_bank #(
      .ADDR_W    (ADDR_W),
      .NSRC      (NSRC),
      .MASK_ADDR (MASK_ADDR),
      .LOCK_KEEP (LOCK_KEEP)
   ) masks_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_bits    (wr_data[NSRC-1:0]),
      .force_ones (force_ones),
      .gen_en     (gen_en),
      .sw_en      (sw_en),
      .locked     (locked),
      .mask       (mask)
   );

   lic_delivery_gate #(
      .NSRC      (NSRC),
      .LOCK_KEEP (LOCK_KEEP)
   ) gate_i (
      .gen_en  (gen_en),
      .sw_en   (sw_en),
      .locked  (locked),
      .mask    (mask),
      .src_req (src_req),
      .irq     (irq)
   );

   assign feature_present = gen_en;
   assign ctl_enabled     = gen_en && sw_en;
   assign gen_locked      = locked;

endmodule

// File: rtl/lic_enable_gate_chk.sv
module lic_enable_gate_chk #(
   parameter int                ADDR_W    = 12,
   parameter int                DATA_W    = 32,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h01B,
   parameter logic [ADDR_W-1:0] SVR_ADDR  = 12'h0F0,
   parameter int                GEN_BIT   = 11,
   parameter int                SWEN_BIT  = 8,
   parameter lic_pkg::lic_bus_e BUS_MODE  = lic_pkg::BUS_FSB
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         wr_en,
   input logic [ADDR_W-1:0]            wr_addr,
   input logic [DATA_W-1:0]            wr_data,
   input logic [lic_pkg::LIC_NSRC-1:0] src_req,
   input logic [lic_pkg::LIC_NSRC-1:0] irq,
   input logic                         feature_present,
   input logic                         ctl_enabled,
   input logic                         gen_locked
);

   localparam logic [lic_pkg::LIC_NSRC-1:0] KEEP = lic_pkg::LIC_LOCK_KEEP;

   // R5
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gen_locked |=> gen_locked);

   // R5
   locked_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gen_locked |-> !feature_present);

   // R2
   gen_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == BASE_ADDR && !wr_data[GEN_BIT]) |=> !feature_present);

   // R4
   fsb_reenable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (BUS_MODE == lic_pkg::BUS_FSB && wr_en && wr_addr == BASE_ADDR && wr_data[GEN_BIT])
      |=> (feature_present && !gen_locked));

   // R10
   irq_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq & ~src_req) == '0);

   // R10
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!gen_locked && !ctl_enabled) |-> irq == '0);

   // R6
   locked_keep_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gen_locked |-> (irq & ~KEEP) == '0);

   // R7
   svr_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == SVR_ADDR && feature_present)
      |=> ctl_enabled == $past(wr_data[SWEN_BIT]));

   // R8
   svr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == SVR_ADDR && !feature_present) |=> !ctl_enabled);

endmodule

bind lic_enable_gate lic_enable_gate_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .BASE_ADDR (BASE_ADDR),
   .SVR_ADDR  (SVR_ADDR),
   .GEN_BIT   (GEN_BIT),
   .SWEN_BIT  (SWEN_BIT),
   .BUS_MODE  (BUS_MODE)
) chk_i (
   .clk             (clk),
   .rst_n           (rst_n),
   .wr_en           (wr_en),
   .wr_addr         (wr_addr),
   .wr_data         (wr_data),
   .src_req         (src_req),
   .irq             (irq),
   .feature_present (feature_present),
   .ctl_enabled     (ctl_enabled),
   .gen_locked      (gen_locked)
);

// File: tb/lic_enable_gate_tb.sv
`timescale 1ns/1ps
module lic_enable_gate_tb_top;

   localparam logic [11:0] A_BASE = 12'h01B;
   localparam logic [11:0] A_SVR  = 12'h0F0;
   localparam logic [11:0] A_MASK = 12'h300;
   localparam logic [5:0]  KEEP   = 6'b011000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [11:0] wr_addr;
   logic [31:0] wr_data;
   logic [5:0]  src_req;

   logic [5:0] irq_f, irq_s;
   logic fp_f, fp_s, en_f, en_s, lk_f, lk_s;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // bench model, index 0 = front-side-bus instance, 1 = three-wire instance
   logic       m_gen  [2];
   logic       m_sw   [2];
   logic       m_lock [2];
   logic [5:0] m_mask [2];

   always #4 clk = ~clk;

   lic_enable_gate #(.BUS_MODE(lic_pkg::BUS_FSB)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .src_req(src_req), .irq(irq_f), .feature_present(fp_f),
      .ctl_enabled(en_f), .gen_locked(lk_f));

   lic_enable_gate #(.BUS_MODE(lic_pkg::BUS_3WIRE)) dut_s (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .src_req(src_req), .irq(irq_s), .feature_present(fp_s),
      .ctl_enabled(en_s), .gen_locked(lk_s));

   function automatic logic [5:0] exp_irq(input int k);
      if (m_lock[k])            return src_req & ~m_mask[k] & KEEP;
      else if (m_gen[k] && m_sw[k]) return src_req & ~m_mask[k];
      else                      return 6'b0;
   endfunction

   task automatic chk(input string tag, input string what, input int k,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s inst=%0d actual=%h expected=%h", tag, what, k, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag, "feature_present", 0, 32'(fp_f), 32'(m_gen[0]));
      chk(tag, "ctl_enabled",     0, 32'(en_f), 32'(m_gen[0] & m_sw[0]));
      chk(tag, "gen_locked",      0, 32'(lk_f), 32'(m_lock[0]));
      chk(tag, "irq",             0, 32'(irq_f), 32'(exp_irq(0)));
      chk(tag, "feature_present", 1, 32'(fp_s), 32'(m_gen[1]));
      chk(tag, "ctl_enabled",     1, 32'(en_s), 32'(m_gen[1] & m_sw[1]));
      chk(tag, "gen_locked",      1, 32'(lk_s), 32'(m_lock[1]));
      chk(tag, "irq",             1, 32'(irq_s), 32'(exp_irq(1)));
   endtask

   task automatic model_reset();
      for (int k = 0; k < 2; k++) begin
         m_gen[k] = 1'b1; m_sw[k] = 1'b0; m_lock[k] = 1'b0; m_mask[k] = 6'h3F;
      end
   endtask

   task automatic model_write(input logic [11:0] a, input logic [31:0] d);
      for (int k = 0; k < 2; k++) begin
         if (a == A_BASE) begin
            if (!d[11]) begin
               m_gen[k] = 1'b0; m_sw[k] = 1'b0; m_mask[k] = 6'h3F;
               if (k == 1) m_lock[k] = 1'b1;
            end else if (!m_lock[k]) begin
               m_gen[k] = 1'b1;
            end
         end else if (a == A_SVR && m_gen[k]) begin
            m_sw[k] = d[8];
            if (!d[8]) m_mask[k] = 6'h3F;
         end else if (a == A_MASK) begin
            if (m_lock[k])              m_mask[k] = (d[5:0] & KEEP) | ~KEEP;
            else if (m_gen[k] && m_sw[k]) m_mask[k] = d[5:0];
         end
      end
   endtask

   task automatic do_reset();
      @(posedge clk); #2;
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      model_reset();
      @(negedge clk);
   endtask

   task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
      @(posedge clk); #2;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #2;
      wr_en = 1'b0;
      model_write(a, d);
      @(negedge clk);
   endtask

   task automatic set_req(input logic [5:0] v);
      @(posedge clk); #2;
      src_req = v;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired before the sequence ended");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; src_req = '0;
      model_reset();
      do_reset();

      // R1: reset state, all requests raised
      set_req(6'h3F);
      check_all("R1");

      // R7: software enable from bit 8 of the spurious-vector register
      reg_wr(A_SVR, 32'h0000_0100);
      check_all("R7");

      // R10 / R11: every mask against every request pattern
      for (int m = 0; m < 64; m++) begin
         reg_wr(A_MASK, 32'(m));
         for (int r = 0; r < 64; r++) begin
            set_req(6'(r));
            check_all("R10");
         end
      end

      // R11: writes to an unmapped address change nothing
      reg_wr(A_MASK, 32'h0000_0000);
      set_req(6'h3F);
      reg_wr(12'h304, 32'hFFFF_FFFF);
      check_all("R11");
      reg_wr(12'h01C, 32'h0000_0000);
      check_all("R11");

      // R9: software disable forces masks; writes while disabled keep them set
      reg_wr(A_SVR, 32'h0000_0000);
      check_all("R9");
      reg_wr(A_MASK, 32'h0000_0000);
      reg_wr(A_SVR, 32'h0000_0100);
      check_all("R9");

      // unmask all again, then clear the global enable
      reg_wr(A_MASK, 32'h0000_0000);
      check_all("R10");
      reg_wr(A_BASE, 32'h0000_0000);
      check_all("R2");
      check_all("R5");

      // R8: spurious-vector writes ignored while globally disabled
      reg_wr(A_SVR, 32'h0000_0100);
      check_all("R8");

      // R6: perf/thermal masks in the locked state
      for (int m = 0; m < 64; m++) begin
         reg_wr(A_MASK, 32'(m));
         for (int r = 0; r < 64; r += 7) begin
            set_req(6'(r));
            check_all("R6");
         end
      end
      reg_wr(A_MASK, 32'h0000_0000);
      set_req(6'h3F);

      // R4 / R5: set the global enable again
      reg_wr(A_BASE, 32'h0000_0800);
      check_all("R4");
      check_all("R5");

      // R3: configuration was wiped; software enable needed again, masks set
      reg_wr(A_SVR, 32'h0000_0100);
      check_all("R3");
      reg_wr(A_MASK, 32'h0000_0015);
      check_all("R3");

      // R5: only hardware reset clears the lock
      do_reset();
      check_all("R5");
      reg_wr(A_BASE, 32'h0000_0000);
      reg_wr(A_BASE, 32'h0000_0800);
      check_all("R5");
      check_all("R4");

      finish_run();
   end

endmodule